// File: doc/BRIEF.md
# Paravirtual Device Common Register Block

This block is the shared control window of a paravirtual I/O function. A host bus master reaches it through a byte-addressed port and may read or write a byte, a halfword or a word. The low part of the window holds the registers that every device type shares. These are the feature masks offered and accepted, the queue selector, and the page frame, size and interrupt vector of the selected queue. The window also holds a device status byte, an interrupt status byte and a vector for configuration changes. Any offset at or above the end of the common region goes out unchanged, with the region size taken off, on a device-specific port.

Some accesses have side effects. A read of the interrupt status byte returns it and clears it. Writing zero to the page frame register or to the status byte resets the device state and raises a one-clock reset pulse. A write to the notify register raises a one-clock strobe that carries the queue index. Queue and configuration events come in as pulses. They set interrupt status bits and either drive a level interrupt line or, with message interrupts enabled, raise a vector request. Turning message interrupts on makes the common region 4 bytes longer, so the device-specific space moves up.

The access port has no back-pressure. The block accepts one access in every cycle that `acc_valid` is high. Every read gives exactly one `rsp_valid` pulse in the following cycle, and the host must always take it. The device-specific port is a same-cycle pass-through. The device returns `dev_cfg_rdata` combinationally in the cycle its read is forwarded.

Top module: `pv_common_regs`

## Requirements
- R1: The common region is 20 bytes with `msix_en` low and 24 bytes with it high. An access at offset N that is not below the region size is forwarded on `dev_cfg_*` in the same cycle with offset N minus the size, and a read of it returns `dev_cfg_rdata`.
- R2: A read gets `rsp_valid` one cycle after it is accepted. The data is the register value masked to the access size (size code 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits). The queue size at offset 12 reads `sel_qsize`. A read of a common offset that starts no register returns all ones, masked the same way. Writes to such offsets and to read-only registers change nothing.
- R3: A read at offset 0 returns `dev_features` with bits 24, 28 and 30 forced to 1.
- R4: A write at offset 4 stores the write value, zero-extended from the access size, as the guest features. If bit 30 of that value is set, 0 is stored instead.
- R5: A nonzero write at offset 8 stores a page frame number for the selected queue. A read returns it, and `sel_queue_base` shows it shifted left by 12.
- R6: Writing 0 at offset 8, or a value with a zero low byte at offset 18, resets the device. Guest features, status, interrupt status, queue select and all page frames become 0, all vectors become 16'hFFFF, events in that cycle are dropped, and `dev_reset` is high for the next cycle.
- R7: A write at offset 18 keeps only the low 8 bits as the device status, which reads back at offset 18.
- R8: A write at offset 14 changes the queue selector only when the value is below NQ. Otherwise the selector is kept. `sel_queue` shows the selector.
- R9: A read at offset 19 returns the interrupt status and clears it in the same access. An event in that same cycle still sets its bit.
- R10: `evt_queue` sets interrupt status bit 0 and `evt_config` sets bit 1. `irq_level` equals bit 0 while `msix_en` is low and is 0 while it is high.
- R11: With `msix_en` high, a write at offset 20 (configuration vector) or 22 (vector of the selected queue) stores the low 16 bits when `vec_ok` is high, and 16'hFFFF otherwise.
- R12: A write at offset 16 gives `notify_valid` for one cycle in the next cycle, with `notify_queue` equal to the low 16 bits written.
- R13: With `msix_en` high, a queue event raises `msi_req` in the next cycle with that queue's stored vector. Without a queue event, a configuration event does the same with the configuration vector. No request is raised when the chosen vector is 16'hFFFF or `msix_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access offered this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| acc_addr | input | AW | Byte offset into the window |
| acc_wdata | input | 32 | Write value, low-aligned |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| dev_cfg_valid | output | 1 | Access forwarded to device space |
| dev_cfg_write | output | 1 | Forwarded direction |
| dev_cfg_size | output | 2 | Forwarded size |
| dev_cfg_addr | output | AW | Offset within device space |
| dev_cfg_wdata | output | 32 | Forwarded write value |
| dev_cfg_rdata | input | 32 | Device read data, same cycle |
| dev_features | input | 32 | Features the device offers |
| sel_queue | output | QW | Selected queue index |
| sel_qsize | input | 16 | Size of the selected queue |
| sel_queue_base | output | 44 | Base address of the selected queue |
| msix_en | input | 1 | Message interrupts enabled |
| vec_ok | input | 1 | Vector written this cycle can be allocated |
| evt_queue | input | 1 | Queue event pulse |
| evt_queue_idx | input | QW | Queue of the event |
| evt_config | input | 1 | Configuration change pulse |
| irq_level | output | 1 | Level interrupt line |
| msi_req | output | 1 | Vector request pulse |
| msi_vector | output | 16 | Vector requested |
| notify_valid | output | 1 | Notify strobe |
| notify_queue | output | 16 | Notified queue index |
| dev_reset | output | 1 | Device reset pulse |

## Verification
The bench targets the boundary at offsets 20 to 23. If the region size did not follow `msix_en`, a vector write would be taken while it should go to the device, or the reverse, and the forwarded offset would be off by four. It reads interrupt status while new events arrive, so a design whose clear wins over the set would lose an interrupt. It writes zero as a byte, as a halfword, and with high bits set but a zero low byte. A design that compared the unmasked write value would miss the reset or trigger it wrongly. It also writes out-of-range selectors, bad-feature masks and vectors that cannot be allocated, and checks them by reading back. In the same cycles it fires events whose vector is being rewritten, so that using the new vector too early shows up on `msi_vector`.

// File: rtl/pvc_pkg.sv
package pvc_pkg;
  localparam logic [15:0] NO_VEC = 16'hFFFF;
  localparam int PFN_SHIFT = 12;
  localparam int FEAT_EMPTY_NOTIFY = 24;
  localparam int FEAT_INDIRECT = 28;
  localparam int FEAT_BAD = 30;
  localparam int CMN_BYTES = 20;
  localparam int CMN_BYTES_MSIX = 24;

  typedef enum logic [3:0] {
    SEL_HOSTF, SEL_GUESTF, SEL_PFN, SEL_QNUM, SEL_QSEL, SEL_NOTIFY,
    SEL_STATUS, SEL_ISR, SEL_CFGVEC, SEL_QVEC, SEL_NONE, SEL_DEV
  } reg_sel_e;

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/pvc_decode.sv
module pvc_decode import pvc_pkg::*; #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic          msix_en,
  output reg_sel_e      sel,
  output logic          fwd,
  output logic [AW-1:0] dev_off
);
  localparam logic [AW-1:0] SZ_PLAIN = AW'(CMN_BYTES);
  localparam logic [AW-1:0] SZ_MSIX  = AW'(CMN_BYTES_MSIX);

  logic [AW-1:0] cmn_size;

  always_comb begin
    cmn_size = msix_en ? SZ_MSIX : SZ_PLAIN;
    fwd      = (addr >= cmn_size);
    dev_off  = addr - cmn_size;
    case (addr)
      AW'(0):  sel = SEL_HOSTF;
      AW'(4):  sel = SEL_GUESTF;
      AW'(8):  sel = SEL_PFN;
      AW'(12): sel = SEL_QNUM;
      AW'(14): sel = SEL_QSEL;
      AW'(16): sel = SEL_NOTIFY;
      AW'(18): sel = SEL_STATUS;
      AW'(19): sel = SEL_ISR;
      AW'(20): sel = SEL_CFGVEC;
      AW'(22): sel = SEL_QVEC;
      default: sel = SEL_NONE;
    endcase
    if (fwd) sel = SEL_DEV;
  end
endmodule

// File: rtl/pvc_qbank.sv
module pvc_qbank import pvc_pkg::*; #(
  parameter int NQ = 16,
  parameter int QW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [QW-1:0] sel,
  input  logic          pfn_we,
  input  logic [31:0]   pfn_wdata,
  input  logic          vec_we,
  input  logic [15:0]   vec_wdata,
  input  logic [QW-1:0] evt_idx,
  output logic [31:0]   sel_pfn,
  output logic [15:0]   sel_vec,
  output logic [15:0]   evt_vec
);
  logic [31:0] pfn_q [NQ];
  logic [15:0] vec_q [NQ];

  for (genvar g = 0; g < NQ; g++) begin : g_queue
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pfn_q[g] <= '0;
        vec_q[g] <= NO_VEC;
      end else if (clr) begin
        pfn_q[g] <= '0;
        vec_q[g] <= NO_VEC;
      end else begin
        if (pfn_we && sel == QW'(g)) pfn_q[g] <= pfn_wdata;
        if (vec_we && sel == QW'(g)) vec_q[g] <= vec_wdata;
      end
    end
  end

  assign sel_pfn = pfn_q[sel];
  assign sel_vec = vec_q[sel];
  assign evt_vec = vec_q[evt_idx];
endmodule

// File: rtl/pvc_isr.sv
module pvc_isr import pvc_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        rd_clr,
  input  logic        evt_queue,
  input  logic        evt_config,
  input  logic        msix_en,
  input  logic [15:0] queue_vec,
  input  logic [15:0] cfg_vec,
  output logic [7:0]  isr,
  output logic        irq_level,
  output logic        msi_req,
  output logic [15:0] msi_vector
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr        <= '0;
      msi_req    <= 1'b0;
      msi_vector <= NO_VEC;
    end else if (clr) begin
      isr     <= '0;
      msi_req <= 1'b0;
    end else begin
      isr     <= (rd_clr ? 8'h00 : isr) | {6'b0, evt_config, evt_queue};
      msi_req <= 1'b0;
      if (msix_en) begin
        if (evt_queue) begin
          msi_req    <= (queue_vec != NO_VEC);
          msi_vector <= queue_vec;
        end else if (evt_config) begin
          msi_req    <= (cfg_vec != NO_VEC);
          msi_vector <= cfg_vec;
        end
      end
    end
  end

  assign irq_level = isr[0] & ~msix_en;
endmodule

// File: rtl/pv_common_regs.sv
module pv_common_regs import pvc_pkg::*; #(
  parameter int AW = 8,
  parameter int NQ = 16,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int BASE_W = 32 + PFN_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_size,
  input  logic [AW-1:0]     acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              dev_cfg_valid,
  output logic              dev_cfg_write,
  output logic [1:0]        dev_cfg_size,
  output logic [AW-1:0]     dev_cfg_addr,
  output logic [31:0]       dev_cfg_wdata,
  input  logic [31:0]       dev_cfg_rdata,
  input  logic [31:0]       dev_features,
  output logic [QW-1:0]     sel_queue,
  input  logic [15:0]       sel_qsize,
  output logic [BASE_W-1:0] sel_queue_base,
  input  logic              msix_en,
  input  logic              vec_ok,
  input  logic              evt_queue,
  input  logic [QW-1:0]     evt_queue_idx,
  input  logic              evt_config,
  output logic              irq_level,
  output logic              msi_req,
  output logic [15:0]       msi_vector,
  output logic              notify_valid,
  output logic [15:0]       notify_queue,
  output logic              dev_reset
);
  localparam logic [31:0] FORCED_FEAT =
    (32'd1 << FEAT_EMPTY_NOTIFY) | (32'd1 << FEAT_INDIRECT) | (32'd1 << FEAT_BAD);

  reg_sel_e      sel;
  logic          fwd;
  logic [AW-1:0] dev_off;
  logic [31:0]   wval, mask, raw;
  logic          wr, rd, dev_clr, pfn_we, qvec_we, isr_rd;
  logic [15:0]   vec_new;
  logic [31:0]   guest_q;
  logic [7:0]    status_q;
  logic [15:0]   cfg_vec_q;
  logic [31:0]   sel_pfn;
  logic [15:0]   sel_vec, evt_vec;
  logic [7:0]    isr_val;

  pvc_decode #(.AW(AW)) u_dec (
    .addr(acc_addr), .msix_en(msix_en), .sel(sel), .fwd(fwd), .dev_off(dev_off)
  );

  assign mask    = size_mask(acc_size);
  assign wval    = acc_wdata & mask;
  assign wr      = acc_valid & acc_write;
  assign rd      = acc_valid & ~acc_write;
  assign dev_clr = wr & (((sel == SEL_PFN) & (wval == 32'd0)) |
                         ((sel == SEL_STATUS) & (wval[7:0] == 8'd0)));
  assign pfn_we  = wr & (sel == SEL_PFN) & (wval != 32'd0);
  assign qvec_we = wr & (sel == SEL_QVEC);
  assign vec_new = vec_ok ? wval[15:0] : NO_VEC;
  assign isr_rd  = rd & (sel == SEL_ISR);

  assign dev_cfg_valid = acc_valid & fwd;
  assign dev_cfg_write = acc_write;
  assign dev_cfg_size  = acc_size;
  assign dev_cfg_addr  = dev_off;
  assign dev_cfg_wdata = acc_wdata;

  pvc_qbank #(.NQ(NQ), .QW(QW)) u_qbank (
    .clk(clk), .rst_n(rst_n), .clr(dev_clr), .sel(sel_queue),
    .pfn_we(pfn_we), .pfn_wdata(wval), .vec_we(qvec_we), .vec_wdata(vec_new),
    .evt_idx(evt_queue_idx), .sel_pfn(sel_pfn), .sel_vec(sel_vec), .evt_vec(evt_vec)
  );

  pvc_isr u_isr (
    .clk(clk), .rst_n(rst_n), .clr(dev_clr), .rd_clr(isr_rd),
    .evt_queue(evt_queue), .evt_config(evt_config), .msix_en(msix_en),
    .queue_vec(evt_vec), .cfg_vec(cfg_vec_q), .isr(isr_val),
    .irq_level(irq_level), .msi_req(msi_req), .msi_vector(msi_vector)
  );

  assign sel_queue_base = {sel_pfn, {PFN_SHIFT{1'b0}}};

  always_comb begin
    case (sel)
      SEL_HOSTF:  raw = dev_features | FORCED_FEAT;
      SEL_GUESTF: raw = guest_q;
      SEL_PFN:    raw = sel_pfn;
      SEL_QNUM:   raw = {16'd0, sel_qsize};
      SEL_QSEL:   raw = 32'(sel_queue);
      SEL_STATUS: raw = {24'd0, status_q};
      SEL_ISR:    raw = {24'd0, isr_val};
      SEL_CFGVEC: raw = {16'd0, cfg_vec_q};
      SEL_QVEC:   raw = {16'd0, sel_vec};
      SEL_DEV:    raw = dev_cfg_rdata;
      default:    raw = 32'hFFFF_FFFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guest_q      <= '0;
      status_q     <= '0;
      sel_queue    <= '0;
      cfg_vec_q    <= NO_VEC;
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      notify_valid <= 1'b0;
      notify_queue <= '0;
      dev_reset    <= 1'b0;
    end else begin
      rsp_valid    <= rd;
      if (rd) rsp_rdata <= raw & mask;
      notify_valid <= wr & (sel == SEL_NOTIFY);
      if (wr && sel == SEL_NOTIFY) notify_queue <= wval[15:0];
      dev_reset    <= dev_clr;
      if (dev_clr) begin
        guest_q   <= '0;
        status_q  <= '0;
        sel_queue <= '0;
        cfg_vec_q <= NO_VEC;
      end else if (wr) begin
        case (sel)
          SEL_GUESTF: guest_q  <= wval[FEAT_BAD] ? 32'd0 : wval;
          SEL_STATUS: status_q <= wval[7:0];
          SEL_QSEL:   if (wval < 32'(NQ)) sel_queue <= wval[QW-1:0];
          SEL_CFGVEC: cfg_vec_q <= vec_new;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pvc_chk.sv
module pvc_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_write,
  input logic [AW-1:0] acc_addr,
  input logic          rsp_valid,
  input logic          dev_cfg_valid,
  input logic [AW-1:0] dev_cfg_addr,
  input logic          msix_en,
  input logic          evt_queue,
  input logic          irq_level,
  input logic          msi_req,
  input logic [15:0]   msi_vector,
  input logic          notify_valid,
  input logic          dev_reset
);
  AST_FWD_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    dev_cfg_valid |-> (AW'(dev_cfg_addr + (msix_en ? AW'(24) : AW'(20))) == acc_addr)); // R1
  AST_FWD_NOT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr < AW'(20)) |-> !dev_cfg_valid); // R1
  AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rsp_valid); // R2
  AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc_valid && !acc_write)); // R2
  AST_RESET_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |-> $past(acc_valid && acc_write)); // R6
  AST_ISR_READ_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_addr == AW'(19) && !evt_queue) |=> !irq_level); // R9
  AST_LINE_QUIET_MSIX: assert property (@(posedge clk) disable iff (!rst_n)
    msix_en |-> !irq_level); // R10
  AST_NOTIFY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> $past(acc_valid && acc_write && acc_addr == AW'(16))); // R12
  AST_MSI_REAL_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> msi_vector != 16'hFFFF); // R13
  AST_MSI_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> $past(msix_en)); // R13
endmodule

bind pv_common_regs pvc_chk #(.AW(AW)) u_chk (.*);

// File: tb/pv_common_regs_tb.sv
module pv_common_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NQ = 16;
  localparam int QW = 4;
  localparam int WD_CYCLES = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0;
  logic [1:0] acc_size = 0;
  logic [AW-1:0] acc_addr = 0;
  logic [31:0] acc_wdata = 0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic dev_cfg_valid, dev_cfg_write;
  logic [1:0] dev_cfg_size;
  logic [AW-1:0] dev_cfg_addr;
  logic [31:0] dev_cfg_wdata;
  logic [31:0] dev_cfg_rdata = 0;
  logic [31:0] dev_features = 32'h0000_0005;
  logic [QW-1:0] sel_queue;
  logic [15:0] sel_qsize;
  logic [43:0] sel_queue_base;
  logic msix_en = 0, vec_ok = 0, evt_queue = 0, evt_config = 0;
  logic [QW-1:0] evt_queue_idx = 0;
  logic irq_level, msi_req, notify_valid, dev_reset;
  logic [15:0] msi_vector, notify_queue;

  int nchk = 0, nerr = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sel_qsize = 16'h40 + {12'd0, sel_queue} * 16'd4;

  pv_common_regs #(.AW(AW), .NQ(NQ)) u_dut (.*);

  // behavioural reference state
  logic [31:0] m_gf, m_pfn [NQ];
  logic [15:0] m_qvec [NQ];
  logic [15:0] m_cvec;
  logic [7:0] m_st, m_isr;
  int m_qsel;
  bit e_rsp, e_notify, e_rst, e_msi;
  logic [31:0] e_data;
  logic [15:0] e_nq, e_mvec;
  string e_tag;

  function automatic logic [31:0] msk(input logic [1:0] s);
    return s == 0 ? 32'hFF : (s == 1 ? 32'hFFFF : 32'hFFFF_FFFF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gf = 0; m_st = 0; m_isr = 0; m_qsel = 0; m_cvec = 16'hFFFF;
      for (int i = 0; i < NQ; i++) begin m_pfn[i] = 0; m_qvec[i] = 16'hFFFF; end
      e_rsp = 0; e_notify = 0; e_rst = 0; e_msi = 0;
    end else begin
      int csz;
      logic [31:0] wv, rv;
      bit clr, rdclr;
      logic [15:0] qv_old, cv_old;
      csz = msix_en ? 24 : 20;
      wv = acc_wdata & msk(acc_size);
      clr = 0; rdclr = 0;
      e_rsp = 0; e_notify = 0; e_rst = 0; e_msi = 0;
      qv_old = m_qvec[evt_queue_idx]; cv_old = m_cvec;
      if (acc_valid && !acc_write) begin
        e_rsp = 1;
        rv = 32'hFFFF_FFFF; e_tag = "R2";
        if (int'(acc_addr) >= csz) begin rv = dev_cfg_rdata; e_tag = "R1"; end
        else case (int'(acc_addr))
          0:  begin rv = dev_features | 32'h5100_0000; e_tag = "R3"; end
          4:  begin rv = m_gf; e_tag = "R4"; end
          8:  begin rv = m_pfn[m_qsel]; e_tag = "R5"; end
          12: rv = 32'h40 + m_qsel * 4;
          14: begin rv = m_qsel; e_tag = "R8"; end
          18: begin rv = m_st; e_tag = "R7"; end
          19: begin rv = m_isr; rdclr = 1; e_tag = "R9"; end
          20: begin rv = m_cvec; e_tag = "R11"; end
          22: begin rv = m_qvec[m_qsel]; e_tag = "R11"; end
          default: ;
        endcase
        e_data = rv & msk(acc_size);
      end else if (acc_valid && int'(acc_addr) < csz) begin
        case (int'(acc_addr))
          4:  m_gf = wv[30] ? 0 : wv;
          8:  if (wv == 0) clr = 1; else m_pfn[m_qsel] = wv;
          14: if (wv < NQ) m_qsel = int'(wv);
          16: begin e_notify = 1; e_nq = wv[15:0]; end
          18: if (wv[7:0] == 0) clr = 1; else m_st = wv[7:0];
          20: m_cvec = vec_ok ? wv[15:0] : 16'hFFFF;
          22: m_qvec[m_qsel] = vec_ok ? wv[15:0] : 16'hFFFF;
          default: ;
        endcase
      end
      if (clr) begin
        m_gf = 0; m_st = 0; m_isr = 0; m_qsel = 0; m_cvec = 16'hFFFF;
        for (int i = 0; i < NQ; i++) begin m_pfn[i] = 0; m_qvec[i] = 16'hFFFF; end
        e_rst = 1;
      end else begin
        m_isr = (rdclr ? 8'h0 : m_isr) | {6'd0, evt_config, evt_queue};
        if (msix_en && evt_queue) begin
          e_msi = (qv_old != 16'hFFFF); e_mvec = qv_old;
        end else if (msix_en && evt_config) begin
          e_msi = (cv_old != 16'hFFFF); e_mvec = cv_old;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_regs();
    chk("R2", "rsp_valid", 64'(rsp_valid), 64'(e_rsp));
    if (e_rsp) chk(e_tag, "rsp_rdata", 64'(rsp_rdata), 64'(e_data));
    chk("R12", "notify_valid", 64'(notify_valid), 64'(e_notify));
    if (e_notify) chk("R12", "notify_queue", 64'(notify_queue), 64'(e_nq));
    chk("R6", "dev_reset", 64'(dev_reset), 64'(e_rst));
    chk("R13", "msi_req", 64'(msi_req), 64'(e_msi));
    if (e_msi) chk("R13", "msi_vector", 64'(msi_vector), 64'(e_mvec));
    chk("R10", "irq_level", 64'(irq_level), 64'(m_isr[0] & ~msix_en));
    chk("R8", "sel_queue", 64'(sel_queue), 64'(m_qsel));
    chk("R5", "sel_queue_base", 64'(sel_queue_base), {m_pfn[m_qsel], 12'd0});
  endtask

  task automatic cmp_fwd();
    int csz;
    bit f;
    csz = msix_en ? 24 : 20;
    f = acc_valid && int'(acc_addr) >= csz;
    chk("R1", "dev_cfg_valid", 64'(dev_cfg_valid), 64'(f));
    if (f) begin
      chk("R1", "dev_cfg_addr", 64'(dev_cfg_addr), 64'(int'(acc_addr) - csz));
      chk("R1", "dev_cfg_fields", {dev_cfg_write, dev_cfg_size, dev_cfg_wdata},
          {acc_write, acc_size, acc_wdata});
    end
  endtask

  task automatic step(input bit v, input bit w, input logic [1:0] sz, input int a,
                      input logic [31:0] d, input bit eq = 0, input int ei = 0,
                      input bit ec = 0, input bit ok = 1);
    @(negedge clk);
    cmp_regs();
    acc_valid = v; acc_write = w; acc_size = sz; acc_addr = AW'(a); acc_wdata = d;
    evt_queue = eq; evt_queue_idx = QW'(ei); evt_config = ec; vec_ok = ok;
    dev_cfg_rdata = $urandom;
    #1 cmp_fwd();
  endtask

  task automatic rd(input logic [1:0] sz, input int a); step(1, 0, sz, a, 0); endtask
  task automatic wr(input logic [1:0] sz, input int a, input logic [31:0] d, input bit ok = 1);
    step(1, 1, sz, a, d, 0, 0, 0, ok);
  endtask
  task automatic idle(); step(0, 0, 0, 0, 0); endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    idle();                               // reset state compared here
    rd(2, 0);                             // R3 host features
    rd(1, 0);
    wr(2, 4, 32'h4000_0011); rd(2, 4);    // R4 bad bit -> 0
    wr(2, 4, 32'h0000_0123); rd(2, 4);    // R4
    wr(0, 4, 32'h4000_0123); rd(2, 4);    // R4 byte write masks bit 30
    wr(1, 14, 16); rd(1, 14);             // R8 ignored
    wr(1, 14, 3); rd(1, 14); rd(1, 12);   // R8, R2 qsize
    wr(2, 8, 32'h000A_BCDE); rd(2, 8);    // R5
    rd(2, 13); rd(0, 1); wr(2, 0, 32'h1234); rd(2, 0); // R2 unmapped / read-only
    step(0, 0, 0, 0, 0, 1, 2, 0); idle(); // R10 line up
    step(1, 0, 0, 19, 0, 0, 0, 1); idle(); rd(0, 19); idle(); // R9 clear with concurrent cfg
    wr(2, 18, 32'h0000_01FF); rd(0, 18);  // R7
    wr(1, 16, 32'h0007_0005); idle();     // R12
    rd(2, 20); rd(2, 21); wr(1, 22, 16'h55); // R1 forwarding at 20..23 plain
    msix_en = 1;
    wr(1, 20, 16'h0007, 0); rd(1, 20);    // R11 alloc fail
    wr(1, 20, 16'h0007, 1); rd(1, 20);    // R11
    wr(1, 22, 16'h0009, 1); rd(1, 22); rd(0, 24); rd(0, 23);
    step(0, 0, 0, 0, 0, 1, 3, 1); idle(); // R13 queue wins
    step(0, 0, 0, 0, 0, 0, 0, 1); idle(); // R13 config
    step(0, 0, 0, 0, 0, 1, 5, 0); idle(); // R13 no vector
    step(1, 1, 1, 22, 16'h0033, 1, 3, 0); idle(); // R13 old vector used
    msix_en = 0;
    wr(0, 18, 32'h0000_0100); rd(2, 4); rd(1, 14); rd(2, 8); // R6 zero low byte
    wr(2, 8, 32'h0000_0042); wr(1, 8, 32'h0001_0000); rd(2, 8); // R6 masked zero
    for (int n = 0; n < 6000; n++) begin
      int a; bit w;
      if ($urandom_range(0, 49) == 0) msix_en = ~msix_en;
      a = $urandom_range(0, 31);
      w = $urandom_range(0, 1);
      step($urandom_range(0, 3) != 0, w, 2'($urandom_range(0, 3)), a,
           ($urandom_range(0, 7) == 0) ? 32'h0 : $urandom,
           $urandom_range(0, 5) == 0, $urandom_range(0, NQ-1),
           $urandom_range(0, 7) == 0, $urandom_range(0, 3) != 0);
    end
    idle(); idle();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog expired (R1..R13 run incomplete) actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule